// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block is the mode state machine of a CAN controller. Software writes a 16-bit control word that requests sleep, one of four operating modes and a bus-off recovery policy, and it also writes a bit-timing word. The sequencer moves the controller between sleep, reset, halt and operation. It reports where it is through a status word that software polls, and it raises a protocol enable for the protocol engine only while it is in operation. Sleep is a separate control bit that sits beside the two-bit mode field. The controller comes out of power-up asleep.

Any move into or out of reset mode takes a fixed synchronisation delay (`SYNC_CYCLES`, default 4). Moves among sleep, halt and operation take effect on the next clock edge. The configuration bits and the bit-timing word can only be changed while the reset-status bit is set, so software must enter reset, wait for the status bit, configure, and then request operation. A bus-off event from the error logic can force the controller into halt on its own, depending on the recovery field.

Top module: `can_mode_seq`

## Requirements
- R1: After reset, the control word reads 0x0500 (sleep requested, mode field 01), the status word reads 0x0400, protocol enable is low, and the bit-timing word reads 0x300001.
- R2: In sleep mode, changes to control bits 9:8 are ignored while control bit 10 is 1. Once bit 10 reads 0, the controller leaves sleep for the mode named in bits 9:8.
- R3: When a transition enters or leaves reset mode, the new mode appears exactly SYNC_CYCLES clock edges after the edge that captured the request. Status bit 8 is 1 exactly while the controller is in reset mode.
- R4: Transitions between sleep, halt and operation take effect on the first clock edge after the request is captured.
- R5: Control bit 10 has no effect in operation mode. From halt, it moves the controller to sleep on the next edge. From reset, it moves the controller to sleep after SYNC_CYCLES edges.
- R6: Control bits 9:8 decode as follows: 00 selects operation, 01 and 11 select reset, and 10 selects halt.
- R7: Control bits 3:0 take a written value only when status bit 8 is 1. Control bits 15:4 take every write.
- R8: A write to the bit-timing word is accepted only when status bit 8 is 1 and the word is legal. Legal means the segment-1 field (bits 23:20) is at least 3 and the segment-2 field (bits 2:0) is at least 1. Any other write is ignored. The reserved bits read 0.
- R9: If the bus-off input is high in operation mode and control bits 12:11 are 01, the controller is in halt after the next edge and control bits 9:8 read 10. With any other value in bits 12:11, bus-off has no effect.
- R10: Protocol enable is high only in operation mode. Status bits 10, 9 and 8 report sleep, halt and reset, and at most one of them is set at a time.
- R11: The decoded timing outputs are each one more than their stored field: segment 1 from bits 23:20, prescaler from bits 17:8, jump width from bits 5:4, and segment 2 from bits 2:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| btc_we | input | 1 | Bit-timing word write strobe |
| btc_wdata | input | 24 | Bit-timing word write data |
| bus_off | input | 1 | Bus-off event from the error logic |
| ctl_rdata | output | 16 | Control word readback |
| sts_rdata | output | 16 | Status: bit 10 sleep, bit 9 halt, bit 8 reset |
| btc_rdata | output | 24 | Bit-timing word readback |
| proto_en | output | 1 | Protocol engine enable |
| seg1_tq | output | 5 | Segment 1 length in time quanta |
| seg2_tq | output | 4 | Segment 2 length in time quanta |
| sjw_tq | output | 3 | Jump width in time quanta |
| brp_div | output | 11 | Prescaler divide ratio |

## Verification
The sequencer is driven through the whole mode graph: wake from sleep into reset, configure, enter operation, halt and resume, forced reset, and sleep entered from both reset and halt. Timing each step separates the delayed path through reset from the one-edge path between the other modes. Mode and configuration writes are repeated in modes where they must be ignored, including a sleep request in operation and an illegal bit-timing word in reset, which shows that the gating depends on both the mode and the legality of the word. Bus-off pulses are sent with the recovery field set to 01 and to 00. This shows that the automatic halt depends on the recovery policy and not on the event alone.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MD_SLEEP = 2'd0,
    MD_RESET = 2'd1,
    MD_HALT  = 2'd2,
    MD_OPER  = 2'd3
  } md_e;

  localparam int unsigned CTL_W   = 16;
  localparam int unsigned BTC_W   = 24;
  localparam int unsigned SLP_BIT = 10;
  localparam logic [CTL_W-1:0] CTL_RST = 16'h0500;
  localparam logic [BTC_W-1:0] BTC_RST = 24'h300001;

  typedef struct packed {
    logic [3:0] seg1;
    logic [9:0] brp;
    logic [1:0] sjw;
    logic [2:0] seg2;
  } btc_t;

  function automatic btc_t btc_unpack(input logic [BTC_W-1:0] w);
    btc_t b;
    b.seg1 = w[23:20];
    b.brp  = w[17:8];
    b.sjw  = w[5:4];
    b.seg2 = w[2:0];
    return b;
  endfunction

  function automatic logic [BTC_W-1:0] btc_pack(input btc_t b);
    return {b.seg1, 2'b00, b.brp, 2'b00, b.sjw, 1'b0, b.seg2};
  endfunction

  // segment 1 at least 4 quanta, segment 2 at least 2 quanta
  function automatic logic btc_legal(input btc_t b);
    return (b.seg1 >= 4'd3) && (b.seg2 >= 3'd1);
  endfunction

  function automatic md_e mode_of_field(input logic [1:0] f);
    case (f)
      2'b00:   return MD_OPER;
      2'b10:   return MD_HALT;
      default: return MD_RESET;
    endcase
  endfunction

  function automatic md_e next_goal(input md_e cur, input logic slp, input logic [1:0] f);
    if (cur == MD_OPER) return mode_of_field(f);
    if (slp)            return MD_SLEEP;
    return mode_of_field(f);
  endfunction

endpackage

// File: rtl/can_mode_regs.sv
module can_mode_regs
  import can_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             btc_we,
  input  logic [BTC_W-1:0] btc_wdata,
  input  logic             cfg_open,
  input  logic             bo_halt,
  output logic [CTL_W-1:0] ctl_q,
  output btc_t             btc_q
);

  btc_t btc_new;
  logic btc_take;

  assign btc_new  = btc_unpack(btc_wdata);
  assign btc_take = btc_we && cfg_open && btc_legal(btc_new);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      btc_q <= btc_unpack(BTC_RST);
    end else begin
      if (ctl_we) begin
        ctl_q[CTL_W-1:4] <= ctl_wdata[CTL_W-1:4];
        if (cfg_open) ctl_q[3:0] <= ctl_wdata[3:0];
      end
      if (bo_halt) ctl_q[9:8] <= 2'b10;
      if (btc_take) btc_q <= btc_new;
    end
  end

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
#(
  parameter int unsigned SYNC_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slp_req,
  input  logic [1:0] mode_fld,
  input  logic [1:0] bor_fld,
  input  logic       bus_off,
  output md_e        cur_q,
  output logic       bo_halt
);

  localparam int unsigned CNT_W = $clog2(SYNC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_CYCLES - 1);

  md_e             goal;
  md_e             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic            slow;

  assign goal    = next_goal(cur_q, slp_req, mode_fld);
  assign slow    = (cur_q == MD_RESET) || (goal == MD_RESET);
  assign bo_halt = (cur_q == MD_OPER) && bus_off && (bor_fld == 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= MD_SLEEP;
      pend_q <= MD_SLEEP;
      cnt_q  <= '0;
    end else if (bo_halt) begin
      cur_q  <= MD_HALT;
      pend_q <= MD_HALT;
      cnt_q  <= '0;
    end else if (goal == cur_q) begin
      pend_q <= cur_q;
      cnt_q  <= '0;
    end else if (!slow) begin
      cur_q  <= goal;
      pend_q <= goal;
      cnt_q  <= '0;
    end else if (pend_q != goal) begin
      pend_q <= goal;
      cnt_q  <= CNT_W'(1);
    end else if (cnt_q >= CNT_LAST) begin
      cur_q  <= goal;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int unsigned SYNC_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [15:0] ctl_wdata,
  input  logic        btc_we,
  input  logic [23:0] btc_wdata,
  input  logic        bus_off,
  output logic [15:0] ctl_rdata,
  output logic [15:0] sts_rdata,
  output logic [23:0] btc_rdata,
  output logic        proto_en,
  output logic [4:0]  seg1_tq,
  output logic [3:0]  seg2_tq,
  output logic [2:0]  sjw_tq,
  output logic [10:0] brp_div
);

  logic [CTL_W-1:0] ctl_q;
  btc_t             btc_q;
  md_e              cur;
  logic             bo_halt;
  logic             cfg_open;

  assign cfg_open = (cur == MD_RESET);

  can_mode_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .btc_we    (btc_we),
    .btc_wdata (btc_wdata),
    .cfg_open  (cfg_open),
    .bo_halt   (bo_halt),
    .ctl_q     (ctl_q),
    .btc_q     (btc_q)
  );

  can_mode_fsm #(.SYNC_CYCLES(SYNC_CYCLES)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .slp_req  (ctl_q[SLP_BIT]),
    .mode_fld (ctl_q[9:8]),
    .bor_fld  (ctl_q[12:11]),
    .bus_off  (bus_off),
    .cur_q    (cur),
    .bo_halt  (bo_halt)
  );

  assign ctl_rdata = ctl_q;
  assign sts_rdata = {5'd0, cur == MD_SLEEP, cur == MD_HALT, cfg_open, 8'd0};
  assign btc_rdata = btc_pack(btc_q);
  assign proto_en  = (cur == MD_OPER);
  assign seg1_tq   = {1'b0, btc_q.seg1} + 5'd1;
  assign seg2_tq   = {1'b0, btc_q.seg2} + 4'd1;
  assign sjw_tq    = {1'b0, btc_q.sjw} + 3'd1;
  assign brp_div   = {1'b0, btc_q.brp} + 11'd1;

endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctl_rdata,
  input logic [15:0] sts_rdata,
  input logic [23:0] btc_rdata,
  input logic        proto_en,
  input logic        bus_off,
  input logic [4:0]  seg1_tq
);

  AST_EN_ONLY_OPER: assert property (@(posedge clk) disable iff (!rst_n)
    proto_en |-> (sts_rdata[10:8] == 3'b000)); // R10

  AST_STS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sts_rdata[10:8])); // R10

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_rdata[8] |=> $stable(ctl_rdata[3:0])); // R7

  AST_BTC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_rdata[8] |=> $stable(btc_rdata)); // R8

  AST_SEG1_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    seg1_tq >= 5'd4); // R8

  AST_BUSOFF_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_en && bus_off && ctl_rdata[12:11] == 2'b01) |=>
      (sts_rdata[9] && ctl_rdata[9:8] == 2'b10)); // R9

  AST_OPER_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    proto_en |=> !sts_rdata[10]); // R5

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_rdata[8]) |-> $past(ctl_rdata[8])); // R3

endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_rdata (ctl_rdata),
  .sts_rdata (sts_rdata),
  .btc_rdata (btc_rdata),
  .proto_en  (proto_en),
  .bus_off   (bus_off),
  .seg1_tq   (seg1_tq)
);

// File: tb/can_mode_seq_tb_top.sv
`timescale 1ns/1ps
module can_mode_seq_tb_top;

  localparam int SYNC = 4;
  localparam int S_SLEEP = 0, S_RESET = 1, S_HALT = 2, S_OPER = 3, S_NONE = -1;

  logic        clk = 0;
  logic        rst_n;
  logic        ctl_we;
  logic [15:0] ctl_wdata;
  logic        btc_we;
  logic [23:0] btc_wdata;
  logic        bus_off;
  logic [15:0] ctl_rdata, sts_rdata;
  logic [23:0] btc_rdata;
  logic        proto_en;
  logic [4:0]  seg1_tq;
  logic [3:0]  seg2_tq;
  logic [2:0]  sjw_tq;
  logic [10:0] brp_div;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  can_mode_seq #(.SYNC_CYCLES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .btc_we(btc_we), .btc_wdata(btc_wdata), .bus_off(bus_off),
    .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata), .btc_rdata(btc_rdata),
    .proto_en(proto_en), .seg1_tq(seg1_tq), .seg2_tq(seg2_tq),
    .sjw_tq(sjw_tq), .brp_div(brp_div)
  );

  // behavioural reference model
  int          m_mode;
  int          m_track;
  int          m_start;
  logic [15:0] m_ctl;
  logic [23:0] m_btc;

  function automatic int field_mode(logic [1:0] f);
    if (f == 2'b00) return S_OPER;
    if (f == 2'b10) return S_HALT;
    return S_RESET;
  endfunction

  function automatic int want_mode(int cur, logic [15:0] c);
    if (cur != S_OPER && c[10]) return S_SLEEP;
    return field_mode(c[9:8]);
  endfunction

  function automatic logic [15:0] sts_of(int md);
    case (md)
      S_SLEEP: return 16'h0400;
      S_HALT:  return 16'h0200;
      S_RESET: return 16'h0100;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = S_SLEEP; m_track = S_NONE; m_start = 0;
      m_ctl = 16'h0500; m_btc = 24'h300001;
    end else begin
      int w;
      bit boff;
      logic [15:0] nctl;
      cyc++;
      w = want_mode(m_mode, m_ctl);
      boff = (m_mode == S_OPER) && bus_off && (m_ctl[12:11] == 2'b01);
      nctl = m_ctl;
      if (ctl_we) begin
        nctl[15:4] = ctl_wdata[15:4];
        if (m_mode == S_RESET) nctl[3:0] = ctl_wdata[3:0];
      end
      if (boff) nctl[9:8] = 2'b10;
      if (btc_we && m_mode == S_RESET && btc_wdata[23:20] >= 3 && btc_wdata[2:0] >= 1)
        m_btc = btc_wdata & 24'hF3FF37;
      if (boff) begin
        m_mode = S_HALT; m_track = S_NONE;
      end else if (w == m_mode) begin
        m_track = S_NONE;
      end else if (w != S_RESET && m_mode != S_RESET) begin
        m_mode = w; m_track = S_NONE;
      end else if (w != m_track) begin
        m_track = w; m_start = cyc;
      end else if (cyc - m_start >= SYNC - 1) begin
        m_mode = w; m_track = S_NONE;
      end
      m_ctl = nctl;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 ctl word", 32'(ctl_rdata), 32'(m_ctl));
      chk("R3 status word", 32'(sts_rdata), 32'(sts_of(m_mode)));
      chk("R10 protocol enable", 32'(proto_en), 32'(m_mode == S_OPER));
      chk("R8 timing word", 32'(btc_rdata), 32'(m_btc));
      chk("R11 seg1", 32'(seg1_tq), 32'(m_btc[23:20]) + 1);
      chk("R11 seg2", 32'(seg2_tq), 32'(m_btc[2:0]) + 1);
      chk("R11 sjw", 32'(sjw_tq), 32'(m_btc[5:4]) + 1);
      chk("R11 brp", 32'(brp_div), 32'(m_btc[17:8]) + 1);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_ctl(logic [15:0] w);
    ctl_we = 1; ctl_wdata = w;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic put_btc(logic [23:0] w);
    btc_we = 1; btc_wdata = w;
    @(negedge clk);
    btc_we = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; ctl_we = 0; ctl_wdata = 0; btc_we = 0; btc_wdata = 0; bus_off = 0;
    step(3);
    rst_n = 1;
    // R1 reset state
    chk("R1 ctl", 32'(ctl_rdata), 32'h0500);
    chk("R1 sts", 32'(sts_rdata), 32'h0400);
    chk("R1 enable", 32'(proto_en), 0);
    chk("R1 timing", 32'(btc_rdata), 32'h300001);
    // R2 mode request ignored while sleep bit held
    put_ctl(16'h0600); step(6);
    chk("R2 still asleep", 32'(sts_rdata), 32'h0400);
    // wake into reset: R3 delay
    put_ctl(16'h0100); step(3);
    chk("R3 reset not yet", 32'(sts_rdata), 32'h0400);
    step(1);
    chk("R3 reset reached", 32'(sts_rdata), 32'h0100);
    // R8 / R11 configuration in reset
    put_btc(24'h700913);
    chk("R8 legal accepted", 32'(btc_rdata), 32'h700913);
    chk("R11 seg1", 32'(seg1_tq), 8);
    chk("R11 seg2", 32'(seg2_tq), 4);
    chk("R11 sjw", 32'(sjw_tq), 2);
    chk("R11 brp", 32'(brp_div), 10);
    put_btc(24'h200913);
    chk("R8 short seg1 rejected", 32'(btc_rdata), 32'h700913);
    put_btc(24'h700910);
    chk("R8 short seg2 rejected", 32'(btc_rdata), 32'h700913);
    put_btc(24'hFFFFFF);
    chk("R8 reserved bits zero", 32'(btc_rdata), 32'hF3FF37);
    put_btc(24'h700913);
    put_ctl(16'h090D);
    chk("R7 low bits in reset", 32'(ctl_rdata), 32'h090D);
    // leave reset for operation
    put_ctl(16'h080D); step(3);
    chk("R3 still in reset", 32'(sts_rdata), 32'h0100);
    step(1);
    chk("R3 reset left", 32'(sts_rdata), 32'h0000);
    chk("R10 enable in operation", 32'(proto_en), 1);
    // R7 / R8 locked outside reset
    put_ctl(16'h0802);
    chk("R7 low bits locked", 32'(ctl_rdata), 32'h080D);
    put_btc(24'h500512);
    chk("R8 locked in operation", 32'(btc_rdata), 32'h700913);
    // R5 sleep ignored in operation
    put_ctl(16'h0C0D); step(6);
    chk("R5 no sleep from operation", 32'(sts_rdata), 32'h0000);
    put_ctl(16'h080D);
    // R4 / R6 halt and back
    put_ctl(16'h0A0D); step(1);
    chk("R6 field 10 halts", 32'(sts_rdata), 32'h0200);
    chk("R10 enable off in halt", 32'(proto_en), 0);
    put_ctl(16'h080D); step(1);
    chk("R4 halt to operation", 32'(sts_rdata), 32'h0000);
    // R9 bus-off with recovery 01
    bus_off = 1; @(negedge clk); bus_off = 0;
    chk("R9 auto halt", 32'(sts_rdata), 32'h0200);
    chk("R9 field rewritten", 32'(ctl_rdata), 32'h0A0D);
    step(3);
    chk("R9 halt held", 32'(sts_rdata), 32'h0200);
    // R9 bus-off with recovery 00
    put_ctl(16'h000D); step(1);
    chk("R4 resume", 32'(sts_rdata), 32'h0000);
    bus_off = 1; @(negedge clk); bus_off = 0;
    chk("R9 no recovery policy", 32'(sts_rdata), 32'h0000);
    chk("R9 field kept", 32'(ctl_rdata), 32'h000D);
    // R6 forced reset
    put_ctl(16'h030D); step(3);
    chk("R6 forced not yet", 32'(sts_rdata), 32'h0000);
    step(1);
    chk("R6 forced reset", 32'(sts_rdata), 32'h0100);
    // R5 sleep from reset takes the delay
    put_ctl(16'h070D); step(3);
    chk("R5 reset before sleep", 32'(sts_rdata), 32'h0100);
    step(1);
    chk("R5 sleep from reset", 32'(sts_rdata), 32'h0400);
    // R2 wake straight to halt
    put_ctl(16'h020D); step(1);
    chk("R2 wake to halt", 32'(sts_rdata), 32'h0200);
    // R5 sleep from halt in one edge
    put_ctl(16'h060D); step(1);
    chk("R5 sleep from halt", 32'(sts_rdata), 32'h0400);
    step(4);
    finish_run();
  end

endmodule